// File: doc/BRIEF.md
# Selectable CNN Activation Unit

This unit takes a stream of signed fixed-point accumulator results from a convolution array and applies one of three activation functions before the value is narrowed to a signed 8-bit result. Every transaction carries its own function code and the type of operation that produced it. A separate input gives the number of fractional bits in the accumulator format, which places the clamp level of the bounded activation. The output is a valid/ready stream of saturated 8-bit values. Each result carries a flag that marks a request the unit refused, and a sticky error flag collects such requests until reset.

The ReLU and ReLU6 functions are always built. The LeakyReLU function uses a fixed slope of about 0.1 and is only built when a parameter enables it. A LeakyReLU request that is not allowed, either because the function was not built or because it came from a depthwise convolution, is computed as plain ReLU and flagged. The output keeps the input's scaling. No shift is applied, apart from the rounding inside the leaky slope. Anything outside the 8-bit range saturates.

Top module: `cnn_act_unit`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0, err_sticky is 0 and in_ready is 1.
- R2: Function code 0 (ReLU) outputs the input when it is not negative and 0 when it is negative.
- R3: Function code 1 (ReLU6) limits a non-negative input to at most 6·2^F, where F is the frac_pos value taken with the transaction. Negative inputs give 0.
- R4: Function code 2 (LeakyReLU, legal and built) passes non-negative inputs unchanged. A negative input x gives floor((26·x + 128) / 256).
- R5: Any activated value above 127 outputs 127, and any value below -128 outputs -128.
- R6: Operation code 1 (depthwise) with function code 2 outputs the ReLU result, sets out_err and sets err_sticky. Operation codes 0 (convolution), 2 (deconvolution) and 3 (treated as convolution) accept function code 2 with out_err 0.
- R7: With LEAKY_EN = 0, function code 2 outputs the ReLU result with out_err 1 and sets err_sticky.
- R8: Function code 3 is reserved. It outputs the ReLU result with out_err 1 and sets err_sticky.
- R9: A transaction accepted on a clock edge is presented on the output after the next clock edge, provided that output is not stalled. Results leave in the order they were accepted.
- R10: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_act and out_err hold their values.
- R11: err_sticky stays 1 once set, until reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Unit accepts the input on this edge |
| in_acc | input | ACC_W | Signed accumulator value |
| in_fn | input | 2 | Function code: 0 ReLU, 1 ReLU6, 2 LeakyReLU, 3 reserved |
| in_op | input | 2 | Operation code: 0 conv, 1 depthwise, 2 deconv, 3 treated as conv |
| frac_pos | input | FRAC_W | Fractional bits of the accumulator format, taken with each transaction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_act | output | OUT_W | Saturated signed result |
| out_err | output | 1 | Result came from a refused request |
| err_sticky | output | 1 | A refused request has been seen since reset |

## Verification
Some properties are checked by the assertions on every cycle. A stalled output stays frozen and input is refused while stalled. Every accepted transaction reaches the output two samples later. The sticky flag never falls outside reset, and any depthwise leaky request, or any leaky request in a build without leaky, raises it. Every flagged result is non-negative. The exact output values can only be shown by the bench's scenarios. These values are the slope rounding at its half points, the ReLU6 clamp at several fractional positions, and saturation at both ends. The scenarios also compare a build with leaky and one without on the same stimulus, and check ordering through a stall.

// File: rtl/act_pkg.sv
package act_pkg;
  typedef enum logic [1:0] {
    FN_RELU  = 2'd0,
    FN_RELU6 = 2'd1,
    FN_LEAKY = 2'd2,
    FN_RSVD  = 2'd3
  } act_fn_e;

  typedef enum logic [1:0] {
    OP_CONV   = 2'd0,
    OP_DW     = 2'd1,
    OP_DECONV = 2'd2,
    OP_SPARE  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/act_resolve.sv
module act_resolve
  import act_pkg::*;
#(
  parameter bit LEAKY_EN = 1'b1
) (
  input  logic [1:0] fn_req,
  input  logic [1:0] op_req,
  output act_fn_e    fn_eff,
  output logic       refused
);
  act_fn_e  fn_in;
  op_kind_e op_in;

  always_comb begin
    fn_in   = act_fn_e'(fn_req);
    op_in   = op_kind_e'(op_req);
    fn_eff  = FN_RELU;
    refused = 1'b0;
    case (fn_in)
      FN_RELU:  fn_eff = FN_RELU;
      FN_RELU6: fn_eff = FN_RELU6;
      FN_LEAKY: begin
        if (!LEAKY_EN || op_in == OP_DW) begin
          fn_eff  = FN_RELU;
          refused = 1'b1;
        end else begin
          fn_eff = FN_LEAKY;
        end
      end
      default: begin
        fn_eff  = FN_RELU;
        refused = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/act_leaky.sv
module act_leaky #(
  parameter int ACC_W       = 24,
  parameter int SLOPE_NUM   = 26,
  parameter int SLOPE_SHIFT = 8
) (
  input  logic signed [ACC_W-1:0] x,
  output logic signed [ACC_W-1:0] y
);
  localparam int PW = ACC_W + SLOPE_SHIFT;

  function automatic logic signed [ACC_W-1:0] slope_round(input logic signed [ACC_W-1:0] v);
    logic signed [PW-1:0] ve;
    logic signed [PW-1:0] prod;
    ve   = PW'(v);
    prod = ve * $signed(PW'(SLOPE_NUM)) + $signed(PW'(1 << (SLOPE_SHIFT - 1)));
    return ACC_W'(prod >>> SLOPE_SHIFT);
  endfunction

  assign y = x[ACC_W-1] ? slope_round(x) : x;
endmodule

// File: rtl/act_core.sv
module act_core
  import act_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int FRAC_W = 4,
  parameter int OUT_W  = 8
) (
  input  logic signed [ACC_W-1:0] x,
  input  logic signed [ACC_W-1:0] leaky_y,
  input  act_fn_e                 fn,
  input  logic [FRAC_W-1:0]       frac,
  output logic signed [OUT_W-1:0] y
);
  localparam int SIX_W = 4 + (1 << FRAC_W);
  localparam int CW    = ((ACC_W > SIX_W) ? ACC_W : SIX_W) + 1;
  localparam logic signed [CW-1:0] OMAX = CW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [CW-1:0] OMIN = -OMAX - CW'(1);

  function automatic logic signed [CW-1:0] six_level(input logic [FRAC_W-1:0] f);
    return $signed(CW'(6) << f);
  endfunction

  function automatic logic signed [OUT_W-1:0] sat_out(input logic signed [CW-1:0] v);
    if (v > OMAX)      return OUT_W'(OMAX);
    else if (v < OMIN) return OUT_W'(OMIN);
    else               return OUT_W'(v);
  endfunction

  logic signed [CW-1:0] xw, lw, six, act_w;

  always_comb begin
    xw  = CW'(x);
    lw  = CW'(leaky_y);
    six = six_level(frac);
    case (fn)
      FN_LEAKY: act_w = lw;
      FN_RELU6: act_w = xw[CW-1] ? '0 : ((xw > six) ? six : xw);
      default:  act_w = xw[CW-1] ? '0 : xw;
    endcase
    y = sat_out(act_w);
  end
endmodule

// File: rtl/act_pipe_reg.sv
module act_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else if (en) begin
      q_valid <= d_valid;
      if (d_valid) q <= d;
    end
  end
endmodule

// File: rtl/cnn_act_unit.sv
module cnn_act_unit
  import act_pkg::*;
#(
  parameter int ACC_W    = 24,
  parameter int FRAC_W   = 4,
  parameter int OUT_W    = 8,
  parameter bit LEAKY_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ACC_W-1:0]  in_acc,
  input  logic [1:0]        in_fn,
  input  logic [1:0]        in_op,
  input  logic [FRAC_W-1:0] frac_pos,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_act,
  output logic              out_err,
  output logic              err_sticky
);
  localparam int S1_W = 2 * ACC_W + 2 + FRAC_W + 1;
  localparam int S2_W = OUT_W + 1;

  logic                    adv;
  logic                    in_fire;
  act_fn_e                 fn_eff;
  logic                    req_refused;
  logic signed [ACC_W-1:0] leaky_in;

  logic                    s1_valid;
  logic [S1_W-1:0]         s1_d, s1_q;
  logic signed [ACC_W-1:0] s1_x, s1_leaky;
  act_fn_e                 s1_fn;
  logic [FRAC_W-1:0]       s1_frac;
  logic                    s1_bad;
  logic signed [OUT_W-1:0] s1_y;

  logic                    s2_valid;
  logic [S2_W-1:0]         s2_q;

  assign adv     = !s2_valid || out_ready;
  assign in_fire = in_valid && adv;
  assign in_ready = adv;

  act_resolve #(.LEAKY_EN(LEAKY_EN)) i_resolve (
    .fn_req (in_fn),
    .op_req (in_op),
    .fn_eff (fn_eff),
    .refused(req_refused)
  );

  generate
    if (LEAKY_EN) begin : g_leaky
      act_leaky #(.ACC_W(ACC_W)) i_leaky (
        .x(in_acc),
        .y(leaky_in)
      );
    end else begin : g_no_leaky
      assign leaky_in = '0;
    end
  endgenerate

  assign s1_d = {in_acc, leaky_in, fn_eff, frac_pos, req_refused};

  act_pipe_reg #(.W(S1_W)) i_stage1 (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (adv),
    .d_valid(in_valid),
    .d      (s1_d),
    .q_valid(s1_valid),
    .q      (s1_q)
  );

  always_comb begin
    s1_x     = s1_q[S1_W-1 -: ACC_W];
    s1_leaky = s1_q[S1_W-ACC_W-1 -: ACC_W];
    s1_fn    = act_fn_e'(s1_q[FRAC_W+2 -: 2]);
    s1_frac  = s1_q[FRAC_W:1];
    s1_bad   = s1_q[0];
  end

  act_core #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) i_core (
    .x      (s1_x),
    .leaky_y(s1_leaky),
    .fn     (s1_fn),
    .frac   (s1_frac),
    .y      (s1_y)
  );

  act_pipe_reg #(.W(S2_W)) i_stage2 (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (adv),
    .d_valid(s1_valid),
    .d      ({s1_y, s1_bad}),
    .q_valid(s2_valid),
    .q      (s2_q)
  );

  assign out_valid = s2_valid;
  assign out_act   = s2_q[S2_W-1:1];
  assign out_err   = s2_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      err_sticky <= 1'b0;
    else if (in_fire && req_refused) err_sticky <= 1'b1;
  end
endmodule

// File: rtl/act_unit_chk.sv
module act_unit_chk #(
  parameter int OUT_W    = 8,
  parameter bit LEAKY_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_fire,
  input logic             in_ready,
  input logic [1:0]       in_fn,
  input logic [1:0]       in_op,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_act,
  input logic             out_err,
  input logic             err_sticky
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (!out_valid && !err_sticky && in_ready);
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_act) && $stable(out_err)));

  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r9_arrives: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> ##1 out_valid);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  a_r6_dw_leaky: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_op == 2'd1 && in_fn == 2'd2) |=> err_sticky);

  a_r7_no_leaky: assert property (@(posedge clk) disable iff (!rst_n)
    (!LEAKY_EN && in_fire && in_fn == 2'd2) |=> err_sticky);

  a_r8_refused_relu: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> !out_act[OUT_W-1]);
endmodule

bind cnn_act_unit act_unit_chk #(.OUT_W(OUT_W), .LEAKY_EN(LEAKY_EN)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_fire   (in_fire),
  .in_ready  (in_ready),
  .in_fn     (in_fn),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_act   (out_act),
  .out_err   (out_err),
  .err_sticky(err_sticky)
);

// File: tb/test_cnn_act_unit.sv
module test_cnn_act_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_acc = '0;
  logic [1:0]  in_fn = '0;
  logic [1:0]  in_op = '0;
  logic [3:0]  frac_pos = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_err, err_sticky;
  logic [7:0]  out_act;
  logic        nl_in_ready, nl_out_valid, nl_out_err, nl_err_sticky;
  logic [7:0]  nl_out_act;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cnn_act_unit i_cnn_act_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_fn(in_fn), .in_op(in_op), .frac_pos(frac_pos),
    .out_valid(out_valid), .out_ready(out_ready), .out_act(out_act),
    .out_err(out_err), .err_sticky(err_sticky)
  );

  cnn_act_unit #(.LEAKY_EN(1'b0)) i_cnn_act_unit_nl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(nl_in_ready),
    .in_acc(in_acc), .in_fn(in_fn), .in_op(in_op), .frac_pos(frac_pos),
    .out_valid(nl_out_valid), .out_ready(out_ready), .out_act(nl_out_act),
    .out_err(nl_out_err), .err_sticky(nl_err_sticky)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int floor_div256(input int t);
    if (t >= 0) return t / 256;
    return -((-t + 255) / 256);
  endfunction

  function automatic bit model_err(input int fn, input int op, input bit le);
    return (fn == 3) || (fn == 2 && (op == 1 || !le));
  endfunction

  function automatic int model_y(input int x, input int fn, input int op, input int fr, input bit le);
    int v;
    if (fn == 2 && !model_err(fn, op, le)) v = (x < 0) ? floor_div256(26 * x + 128) : x;
    else if (fn == 1) v = (x < 0) ? 0 : ((x > 6 * (1 << fr)) ? 6 * (1 << fr) : x);
    else v = (x < 0) ? 0 : x;
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    return v;
  endfunction

  task automatic drive(input int x, input int fn, input int op, input int fr);
    in_valid = 1'b1;
    in_acc   = 24'(x);
    in_fn    = 2'(fn);
    in_op    = 2'(op);
    frac_pos = 4'(fr);
  endtask

  // one transaction, output sampled after the second edge from acceptance
  task automatic run1(input string req, input int x, input int fn, input int op, input int fr);
    @(negedge clk);
    drive(x, fn, op, fr);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(req, "out_valid", int'(out_valid), 1);
    chk(req, "out_act", int'($signed(out_act)), model_y(x, fn, op, fr, 1'b1));
    chk(req, "out_err", int'(out_err), int'(model_err(fn, op, 1'b1)));
    chk(req, "nl out_act", int'($signed(nl_out_act)), model_y(x, fn, op, fr, 1'b0));
    chk(req, "nl out_err", int'(nl_out_err), int'(model_err(fn, op, 1'b0)));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "err_sticky in reset", int'(err_sticky), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_relu();
    run1("R2", 50, 0, 0, 4);
    run1("R2", -50, 0, 0, 4);
    run1("R2", 0, 0, 2, 4);
    run1("R5", 300, 0, 0, 4);
  endtask

  task automatic t_relu6();
    run1("R3", 50, 1, 0, 4);
    run1("R3", 200, 1, 0, 4);
    run1("R3", 96, 1, 1, 4);
    run1("R3", -3, 1, 0, 4);
    run1("R3", 7, 1, 0, 0);
    run1("R5", 190, 1, 0, 5);
  endtask

  task automatic t_leaky();
    run1("R4", -10, 2, 0, 0);
    run1("R4", -4, 2, 0, 0);
    run1("R4", -5, 2, 2, 0);
    run1("R4", -300, 2, 0, 0);
    run1("R4", 40, 2, 3, 0);
    run1("R5", -2000, 2, 0, 0);
    run1("R5", 500, 2, 2, 0);
    chk("R6", "err_sticky after legal leaky", int'(err_sticky), 0);
    chk("R7", "nl err_sticky after leaky", int'(nl_err_sticky), 1);
  endtask

  task automatic t_depthwise();
    run1("R6", -100, 2, 1, 0);
    chk("R6", "err_sticky after dw leaky", int'(err_sticky), 1);
    run1("R6", 200, 1, 1, 4);
    chk("R11", "err_sticky held", int'(err_sticky), 1);
  endtask

  task automatic t_reserved();
    run1("R8", -7, 3, 0, 0);
    run1("R8", 9, 3, 2, 0);
    chk("R11", "err_sticky still held", int'(err_sticky), 1);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    drive(11, 0, 0, 0);
    @(negedge clk);
    drive(22, 0, 0, 0);
    @(negedge clk);
    chk("R10", "out_valid stalled", int'(out_valid), 1);
    chk("R9", "first out", int'($signed(out_act)), 11);
    chk("R10", "in_ready stalled", int'(in_ready), 0);
    drive(33, 0, 0, 0);
    @(negedge clk);
    chk("R10", "held data", int'($signed(out_act)), 11);
    chk("R10", "held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9", "second out", int'($signed(out_act)), 22);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9", "third out", int'($signed(out_act)), 33);
    chk("R9", "third valid", int'(out_valid), 1);
    @(negedge clk);
    chk("R9", "drained", int'(out_valid), 0);
  endtask

  task automatic t_reset_clears();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11", "sticky cleared by reset", int'(err_sticky), 0);
    chk("R1", "out_valid cleared by reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_relu();
    t_relu6();
    t_leaky();
    t_depthwise();
    t_reserved();
    t_stall();
    t_reset_clears();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule